// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a calendar clock that a host reaches through a plain byte-wide memory port spanning a 13-bit address space. The eight highest byte addresses, 0x1FF8 up to 0x1FFF, are clock bytes. Every other address falls into a small scratch RAM, which is aliased over the lower part of the space. The clock keeps seconds, minutes, hours (24-hour), day of week, date, month and a two-digit year, all in BCD. These running counters are kept apart from the bytes the host sees. Whenever a second completes, the block copies the counters into a set of holding bytes, and the host reads and writes those holding bytes with the same cycle it uses for ordinary memory.

Time is derived from an input tick. A prescaler counts `SUB_TICKS` ticks to make one second. The lowest clock byte is a control byte with three parts:
- a freeze bit, so that a multi-byte read is coherent;
- a set bit, which stops the copy so that the host can compose a new time and then load it into the counters;
- a six-bit calibration value, which the block only stores and drives onto an output.

When the power-good flag is low, the host port is deselected and cannot write, but timekeeping carries on.

Top module: `bcd_rtc_mem`

## Requirements
- R1: Address decoding. An address with bits 12:3 all ones selects a clock byte by bits 2:0: 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of week, 5 date, 6 month, 7 year. A read request (`cs`=1, `we`=0) puts the selected byte on `rdata` after the next rising clock edge.
- R2: After reset, the clock bytes read 0x00 (control), 0x00, 0x00, 0x00, 0x01, 0x01, 0x01, 0x00, which is 00:00:00 on day 1, 01/01/00.
- R3: Every `SUB_TICKS`-th `tick` completes a second. On that edge the counters advance by one second. The same edge copies the new counter values into the seven time bytes, provided control bits 7 and 6 are both 0.
- R4: A rollover carries into the next field on the same edge. Seconds and minutes wrap 59→00, hours wrap 23→00, date wraps to 01 after the last day of the month, month wraps 12→01 and year wraps 99→00. So 23:59:59 31/12/99 becomes 00:00:00 01/01/00.
- R5: Month lengths. Months 04, 06, 09 and 11 have 30 days. Month 02 has 29 days when the year is a multiple of 4 (00 included) and 28 otherwise. All other months have 31 days.
- R6: Day of week counts 1 to 7. It advances at midnight and wraps from 7 to 1.
- R7: While control bit 6 is 1, the holding bytes are not refreshed, but the counters keep running. After the bit is cleared, the next completed second shows the full elapsed time.
- R8: While control bit 7 is 1, the holding bytes are not refreshed. A host write that changes bit 7 from 1 to 0 loads all seven counters from the holding bytes and clears the prescaler. The next second then completes after `SUB_TICKS` further ticks.
- R9: Control bits 5:0 (bit 5 sign, bits 4:0 magnitude) are plain storage. They are driven on `cal_out` and read back unchanged.
- R10: While `pwr_ok` is 0, host writes have no effect, reads return 0x00, and the counters and the refresh continue.
- R11: If a host write to a time byte falls in the same cycle as a refresh, the host data wins for that byte. The other bytes still refresh.
- R12: Any other address reads back the byte last written to scratch RAM location `addr[RAM_AW-1:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Sub-second time pulse, one cycle wide |
| pwr_ok | input | 1 | Supply good; 0 write-protects and deselects the host port |
| cs | input | 1 | Host access request |
| we | input | 1 | 1 write, 0 read |
| addr | input | 13 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| cal_out | output | 6 | Stored calibration sign and magnitude |

## Verification
Two functions can meet in one cycle: the once-a-second refresh of the holding bytes and a host write to one of those same bytes. The bench provokes this by driving the second-completing tick and a write to the seconds byte on the same clock edge. It then expects the written value in the seconds byte, and expects the running count, seen at the next second, to be unaffected. A second meeting point is the clearing of the set bit partway through a second. The bench places that write after a partial count of ticks, and judges from the read-back seconds value that the prescaler restarted from zero.

// File: rtl/bcd_rtc_mem.sv
module bcd_rtc_mem #(
  parameter int SUB_TICKS = 4,
  parameter int RAM_AW    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        pwr_ok,
  input  logic        cs,
  input  logic        we,
  input  logic [12:0] addr,
  input  logic [7:0]  wdata,
  output logic [7:0]  rdata,
  output logic [5:0]  cal_out
);
  localparam int PW = (SUB_TICKS > 1) ? $clog2(SUB_TICKS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(SUB_TICKS - 1);
  localparam int RAM_N = 1 << RAM_AW;

  logic [7:0]    hold_q [0:7];
  logic [7:0]    cnt_q  [1:7];
  logic [7:0]    nt     [1:7];
  logic [7:0]    ram    [0:RAM_N-1];
  logic [PW-1:0] pre_q;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic host_wr, host_rd, clk_sel, wr_ctrl, load, sec_pulse;
  assign host_wr   = cs & we & pwr_ok;
  assign host_rd   = cs & ~we;
  assign clk_sel   = &addr[12:3];
  assign wr_ctrl   = host_wr & clk_sel & (addr[2:0] == 3'd0);
  assign load      = wr_ctrl & hold_q[0][7] & ~wdata[7];
  assign sec_pulse = tick & (pre_q == PRE_LAST);
  assign cal_out   = hold_q[0][5:0];

  logic [7:0] c_sec, c_min, c_hr, c_dow, c_date, c_mon, c_yr;
  assign c_sec  = cnt_q[1];
  assign c_min  = cnt_q[2];
  assign c_hr   = cnt_q[3];
  assign c_dow  = cnt_q[4];
  assign c_date = cnt_q[5];
  assign c_mon  = cnt_q[6];
  assign c_yr   = cnt_q[7];

  logic [1:0] yr_mod4;
  logic       leap;
  logic [7:0] last_day;
  assign yr_mod4 = {c_yr[4], 1'b0} + c_yr[1:0];
  assign leap    = (yr_mod4 == 2'd0);

  always_comb begin
    case (c_mon)
      8'h02:                      last_day = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
      default:                    last_day = 8'h31;
    endcase
  end

  logic s_wrap, m_wrap, h_wrap, d_wrap, mo_wrap;
  assign s_wrap  = (c_sec == 8'h59);
  assign m_wrap  = s_wrap & (c_min == 8'h59);
  assign h_wrap  = m_wrap & (c_hr == 8'h23);
  assign d_wrap  = h_wrap & (c_date == last_day);
  assign mo_wrap = d_wrap & (c_mon == 8'h12);

  assign nt[1] = s_wrap ? 8'h00 : bcd_inc(c_sec);
  assign nt[2] = !s_wrap ? c_min : (c_min == 8'h59) ? 8'h00 : bcd_inc(c_min);
  assign nt[3] = !m_wrap ? c_hr  : (c_hr == 8'h23)  ? 8'h00 : bcd_inc(c_hr);
  assign nt[4] = !h_wrap ? c_dow : (c_dow == 8'h07) ? 8'h01 : bcd_inc(c_dow);
  assign nt[5] = !h_wrap ? c_date : d_wrap ? 8'h01 : bcd_inc(c_date);
  assign nt[6] = !d_wrap ? c_mon : mo_wrap ? 8'h01 : bcd_inc(c_mon);
  assign nt[7] = !mo_wrap ? c_yr : (c_yr == 8'h99) ? 8'h00 : bcd_inc(c_yr);

  always_ff @(posedge clk) begin
    if (!rst_n) pre_q <= '0;
    else if (load) pre_q <= '0;
    else if (tick) pre_q <= sec_pulse ? '0 : pre_q + PW'(1);
  end

  generate
    for (genvar i = 1; i < 8; i++) begin : g_cnt
      localparam logic [7:0] RV = (i >= 4 && i <= 6) ? 8'h01 : 8'h00;
      always_ff @(posedge clk) begin
        if (!rst_n) cnt_q[i] <= RV;
        else if (load) cnt_q[i] <= hold_q[i];
        else if (sec_pulse) cnt_q[i] <= nt[i];
      end
      always_ff @(posedge clk) begin
        if (!rst_n) hold_q[i] <= RV;
        else if (host_wr && clk_sel && addr[2:0] == 3'(i)) hold_q[i] <= wdata;
        else if (sec_pulse && !hold_q[0][7] && !hold_q[0][6]) hold_q[i] <= nt[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q[0] <= 8'h00;
    else if (wr_ctrl) hold_q[0] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (host_wr && !clk_sel) ram[addr[RAM_AW-1:0]] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= 8'h00;
    else if (host_rd) begin
      if (!pwr_ok) rdata <= 8'h00;
      else if (clk_sel) rdata <= hold_q[addr[2:0]];
      else rdata <= ram[addr[RAM_AW-1:0]];
    end
  end

  AST_PRE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> pre_q == '0); // R8
  AST_READ_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q[0][6] && !(host_wr && clk_sel) |=> $stable(hold_q[1]) && $stable(hold_q[7])); // R7
  AST_WRITE_PROTECT: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_ok |=> $stable(hold_q[0])); // R10
  AST_SEC_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse && !load |=> cnt_q[1] != $past(cnt_q[1])); // R3
  AST_MIN_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse && !load && c_sec == 8'h59 |=> cnt_q[1] == 8'h00 && cnt_q[2] != $past(cnt_q[2])); // R4
  AST_DOW_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    sec_pulse && !load && h_wrap && c_dow == 8'h07 |=> cnt_q[4] == 8'h01); // R6
  AST_HOST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr && clk_sel && addr[2:0] == 3'd1 |=> hold_q[1] == $past(wdata)); // R11
endmodule

// File: tb/bcd_rtc_mem_tb_top.sv
module bcd_rtc_mem_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int SUB = 4;
  localparam logic [12:0] A_CTL = 13'h1FF8, A_SEC = 13'h1FF9, A_MIN = 13'h1FFA,
    A_HR = 13'h1FFB, A_DOW = 13'h1FFC, A_DATE = 13'h1FFD, A_MON = 13'h1FFE, A_YR = 13'h1FFF;

  logic clk = 0, rst_n = 0, tick = 0, pwr_ok = 1, cs = 0, we = 0;
  logic [12:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [5:0] cal_out;
  int checks = 0, errors = 0;
  bit done = 0;

  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_v = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bcd_rtc_mem #(.SUB_TICKS(SUB), .RAM_AW(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_ok(pwr_ok), .cs(cs), .we(we),
    .addr(addr), .wdata(wdata), .rdata(rdata), .cal_out(cal_out));

  always @(posedge clk) rd_v <= cs & ~we;

  always @(negedge clk) begin
    if (rd_v && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (rdata !== e) begin
        errors++;
        $display("FAIL %s: got %02h expected %02h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1; we = 1; addr = a; wdata = d;
    @(negedge clk); cs = 0; we = 0;
  endtask

  task automatic rd(input logic [12:0] a, input logic [7:0] e, input string t);
    @(negedge clk); cs = 1; we = 0; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); cs = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic set_time(input logic [7:0] yr, mo, dt, dw, hr, mi, se);
    wr(A_CTL, 8'h80);
    wr(A_SEC, se); wr(A_MIN, mi); wr(A_HR, hr); wr(A_DOW, dw);
    wr(A_DATE, dt); wr(A_MON, mo); wr(A_YR, yr);
    wr(A_CTL, 8'h00);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 R2 reset contents
    rd(A_CTL, 8'h00, "R2 ctrl"); rd(A_SEC, 8'h00, "R2 sec"); rd(A_MIN, 8'h00, "R2 min");
    rd(A_HR, 8'h00, "R2 hr"); rd(A_DOW, 8'h01, "R1 dow"); rd(A_DATE, 8'h01, "R1 date");
    rd(A_MON, 8'h01, "R2 mon"); rd(A_YR, 8'h00, "R2 yr");
    // R12 scratch RAM
    wr(13'h0012, 8'hA5); wr(13'h1FF7, 8'h3C);
    rd(13'h0012, 8'hA5, "R12 ram lo"); rd(13'h1FF7, 8'h3C, "R12 ram hi");
    // R8 set mode
    wr(A_CTL, 8'h80);
    wr(A_SEC, 8'h58); wr(A_MIN, 8'h59); wr(A_HR, 8'h23); wr(A_DOW, 8'h07);
    wr(A_DATE, 8'h31); wr(A_MON, 8'h12); wr(A_YR, 8'h99);
    ticks(SUB);
    rd(A_SEC, 8'h58, "R8 no refresh while set");
    ticks(2);
    wr(A_CTL, 8'h00);
    ticks(SUB - 1);
    rd(A_SEC, 8'h58, "R8 prescaler cleared");
    ticks(1);
    rd(A_SEC, 8'h59, "R3 second step");
    ticks(SUB);
    // R4 R6 full rollover
    rd(A_SEC, 8'h00, "R4 sec"); rd(A_MIN, 8'h00, "R4 min"); rd(A_HR, 8'h00, "R4 hr");
    rd(A_DOW, 8'h01, "R6 dow wrap"); rd(A_DATE, 8'h01, "R4 date");
    rd(A_MON, 8'h01, "R4 mon"); rd(A_YR, 8'h00, "R4 yr");
    // R5 month lengths
    set_time(8'h24, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); ticks(SUB);
    rd(A_DATE, 8'h29, "R5 leap date"); rd(A_MON, 8'h02, "R5 leap mon"); rd(A_DOW, 8'h04, "R6 dow inc");
    set_time(8'h23, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); ticks(SUB);
    rd(A_DATE, 8'h01, "R5 common date"); rd(A_MON, 8'h03, "R5 common mon");
    set_time(8'h00, 8'h02, 8'h28, 8'h03, 8'h23, 8'h59, 8'h59); ticks(SUB);
    rd(A_DATE, 8'h29, "R5 year00 leap");
    set_time(8'h23, 8'h04, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59); ticks(SUB);
    rd(A_DATE, 8'h01, "R5 30day date"); rd(A_MON, 8'h05, "R5 30day mon");
    set_time(8'h23, 8'h01, 8'h30, 8'h03, 8'h23, 8'h59, 8'h59); ticks(SUB);
    rd(A_DATE, 8'h31, "R5 31day date"); rd(A_MON, 8'h01, "R5 31day mon");
    // R7 read freeze
    set_time(8'h23, 8'h06, 8'h15, 8'h02, 8'h10, 8'h00, 8'h00); ticks(SUB);
    rd(A_SEC, 8'h01, "R3 refresh");
    wr(A_CTL, 8'h40);
    ticks(2 * SUB);
    rd(A_SEC, 8'h01, "R7 frozen sec"); rd(A_HR, 8'h10, "R7 frozen hr");
    wr(A_CTL, 8'h00);
    ticks(SUB);
    rd(A_SEC, 8'h04, "R7 elapsed time");
    // R9 calibration storage
    wr(A_CTL, 8'h2B);
    @(negedge clk);
    checks++;
    if (cal_out !== 6'h2B) begin
      errors++;
      $display("FAIL R9 cal_out: got %02h expected %02h", cal_out, 6'h2B);
    end
    rd(A_CTL, 8'h2B, "R9 ctrl readback");
    wr(A_CTL, 8'h00);
    // R10 power fail
    pwr_ok = 0;
    wr(13'h0012, 8'h5A); wr(A_CTL, 8'h40);
    rd(A_SEC, 8'h00, "R10 deselected read");
    ticks(SUB);
    pwr_ok = 1;
    rd(A_SEC, 8'h05, "R10 time kept");
    rd(A_CTL, 8'h00, "R10 ctrl write blocked");
    rd(13'h0012, 8'hA5, "R10 ram write blocked");
    // R11 same-cycle host write and refresh
    ticks(SUB - 1);
    @(negedge clk); tick = 1; cs = 1; we = 1; addr = A_SEC; wdata = 8'h33;
    @(negedge clk); tick = 0; cs = 0; we = 0;
    rd(A_SEC, 8'h33, "R11 host wins");
    rd(A_MIN, 8'h00, "R11 other byte");
    ticks(SUB);
    rd(A_SEC, 8'h07, "R11 count unaffected");
    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R1 read latency: got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    summary();
    $finish;
  end
endmodule